// File: doc/BRIEF.md
# Character LCD Controller Host Register Interface

This block is the part of a character LCD controller that faces the host processor. The host drives an 8-bit parallel bus with a register select line, a read/write line and an enable strobe. Every transaction is taken on the falling edge of the enable strobe, after that edge has been brought into the system clock domain. With register select low, the host writes instructions or reads a status byte. With register select high, it writes or reads words in one of three internal RAMs: display data, character generator or segment.

Reads are prefetched. An address-set instruction and every data read fetch the word at the current address into an internal data register. The host's next data read returns that word straight away. Data writes go through to the selected RAM at the address counter with no further host action. After each RAM access the address counter steps up or down and wraps within the size of the selected RAM. A busy flag covers each internal operation, and the block refuses work while it is set.

Top module: `lcd_host_if`

## Requirements
- R1: After reset, a status read returns 0x00 (not busy, address 0), the display RAM is the target and the counter direction is increment.
- R2: A read with register select low and read/write high returns the busy flag on bit 7 and the address counter on bits 6:0. It is allowed while busy and changes nothing.
- R3: Instruction writes decode as follows. 1aaaaaaa selects the display RAM at address aaaaaaa. 01aaaaaa selects the character generator RAM. 001aaaaa selects the segment RAM. Each loads the address counter with the operand.
- R4: After an address-set instruction, the next data read returns the word stored at the new address.
- R5: A data write (register select high, read/write low) stores the byte in the target RAM at the address counter, then steps the counter.
- R6: After each data read, the counter steps and the word at the new address is fetched, so consecutive reads return consecutive words.
- R7: Instruction 000001d0 sets the step direction: d=1 increments, d=0 decrements.
- R8: The counter wraps modulo the size of the selected RAM (128, 64 and 32 words by default), in both directions.
- R9: Each accepted instruction write, data write or data read raises the busy flag for BUSY_CYC clock cycles, after which it clears.
- R10: While busy is set, instruction writes, data writes and data reads are ignored. RAM, counter and direction stay unchanged.
- R11: The three RAMs are independent. The same address in different RAMs holds different words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busRs | input | 1 | Register select: 0 instruction/status, 1 data |
| busRw | input | 1 | 1 read, 0 write |
| busEn | input | 1 | Enable strobe; the transaction is taken on its falling edge |
| busDin | input | 8 | Write data from host |
| busDout | output | 8 | Read data to host: status byte or prefetched data word |

## Verification
The bench builds the block with BUSY_CYC set to 32 and keeps the default RAM sizes of 128, 64 and 32 words. The long busy window lets the bench land a status read, a data write and an address-set instruction inside one busy period, so the busy bit and the ignored accesses can be seen at the ports. With the full default sizes, the bench reaches the top address of every RAM, and the wrap points are exercised by single address-set instructions rather than long walks.

// File: rtl/lcd_host_pkg.sv
package lcd_host_pkg;

  typedef enum logic [1:0] {
    TGT_DISP = 2'd0,
    TGT_CGEN = 2'd1,
    TGT_SEGM = 2'd2
  } tgt_e;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic       memWr;
    logic       acStep;
    logic       acLoad;
    logic [6:0] acVal;
    tgt_e       tgtVal;
    logic       fetch;
    logic       dirLoad;
    logic       dirInc;
    logic [7:0] wrData;
  } ctl_s;

endpackage

// File: rtl/lcd_host_ctl.sv
module lcd_host_ctl
  import lcd_host_pkg::*;
#(
  parameter int BUSY_CYC = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busRs,
  input  logic       busRw,
  input  logic       busEn,
  input  logic [7:0] busDin,
  output ctl_s       ctl,
  output logic       busy
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic [2:0] enSh;
  logic [1:0] rsSh, rwSh;
  logic [7:0] dinS1, dinS2;
  logic [CW-1:0] busyCnt;
  logic pendFetch;
  logic enFall, accept, opAccepted, rdAccepted;
  logic rsS, rwS;

  // bring the bus into the clock domain; rs/rw/data ride along with enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enSh  <= '0;
      rsSh  <= '0;
      rwSh  <= '0;
      dinS1 <= '0;
      dinS2 <= '0;
    end else begin
      enSh  <= {enSh[1:0], busEn};
      rsSh  <= {rsSh[0], busRs};
      rwSh  <= {rwSh[0], busRw};
      dinS1 <= busDin;
      dinS2 <= dinS1;
    end
  end

  assign rsS    = rsSh[1];
  assign rwS    = rwSh[1];
  assign enFall = enSh[2] & ~enSh[1];
  assign busy   = (busyCnt != '0);
  assign accept = enFall & ~busy;

  always_comb begin
    ctl        = '0;
    ctl.tgtVal = TGT_DISP;
    ctl.fetch  = pendFetch;
    ctl.wrData = dinS2;
    rdAccepted = 1'b0;
    if (accept) begin
      unique case ({rsS, rwS})
        2'b00: begin
          if (dinS2[7]) begin
            ctl.acLoad = 1'b1;
            ctl.acVal  = dinS2[6:0];
            ctl.tgtVal = TGT_DISP;
          end else if (dinS2[6]) begin
            ctl.acLoad = 1'b1;
            ctl.acVal  = {1'b0, dinS2[5:0]};
            ctl.tgtVal = TGT_CGEN;
          end else if (dinS2[5]) begin
            ctl.acLoad = 1'b1;
            ctl.acVal  = {2'b00, dinS2[4:0]};
            ctl.tgtVal = TGT_SEGM;
          end else if (dinS2[7:2] == 6'b000001) begin
            ctl.dirLoad = 1'b1;
            ctl.dirInc  = dinS2[1];
          end
        end
        2'b10: begin
          ctl.memWr  = 1'b1;
          ctl.acStep = 1'b1;
        end
        2'b11: begin
          ctl.acStep = 1'b1;
          rdAccepted = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign opAccepted = accept & ~(~rsS & rwS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt   <= '0;
      pendFetch <= 1'b0;
    end else begin
      pendFetch <= ctl.acLoad | rdAccepted;
      if (opAccepted)
        busyCnt <= CW'(BUSY_CYC);
      else if (busy)
        busyCnt <= busyCnt - 1'b1;
    end
  end

endmodule

// File: rtl/lcd_host_dp.sv
module lcd_host_dp
  import lcd_host_pkg::*;
#(
  parameter int DISP_AW = 7,
  parameter int CGEN_AW = 6,
  parameter int SEGM_AW = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctl_s       ctl,
  input  logic       busy,
  input  logic       busRs,
  output logic [7:0] busDout,
  output logic [6:0] acQ,
  output tgt_e       tgtQ,
  output logic       dirIncQ
);
  localparam logic [6:0] DISP_MASK = 7'((1 << DISP_AW) - 1);
  localparam logic [6:0] CGEN_MASK = 7'((1 << CGEN_AW) - 1);
  localparam logic [6:0] SEGM_MASK = 7'((1 << SEGM_AW) - 1);

  logic [7:0] dataQ;
  logic [7:0] rdWord [3];
  logic [7:0] selWord;
  logic [6:0] acNext;

  function automatic logic [6:0] maskOf(tgt_e t);
    case (t)
      TGT_CGEN: return CGEN_MASK;
      TGT_SEGM: return SEGM_MASK;
      default:  return DISP_MASK;
    endcase
  endfunction

  assign acNext = (dirIncQ ? acQ + 7'd1 : acQ - 7'd1) & maskOf(tgtQ);

  for (genvar g = 0; g < 3; g++) begin : g_ram
    localparam int AW = (g == 0) ? DISP_AW : (g == 1) ? CGEN_AW : SEGM_AW;
    logic [7:0] mem [2**AW];
    always_ff @(posedge clk) begin
      if (ctl.memWr && tgtQ == tgt_e'(g))
        mem[acQ[AW-1:0]] <= ctl.wrData;
    end
    assign rdWord[g] = mem[acQ[AW-1:0]];
  end

  always_comb begin
    case (tgtQ)
      TGT_CGEN: selWord = rdWord[1];
      TGT_SEGM: selWord = rdWord[2];
      default:  selWord = rdWord[0];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acQ     <= '0;
      tgtQ    <= TGT_DISP;
      dirIncQ <= 1'b1;
      dataQ   <= '0;
    end else begin
      if (ctl.acLoad) begin
        acQ  <= ctl.acVal & maskOf(ctl.tgtVal);
        tgtQ <= ctl.tgtVal;
      end else if (ctl.acStep) begin
        acQ <= acNext;
      end
      if (ctl.dirLoad) dirIncQ <= ctl.dirInc;
      if (ctl.fetch)   dataQ   <= selWord;
    end
  end

  assign busDout = busRs ? dataQ : {busy, acQ};

endmodule

// File: rtl/lcd_host_if.sv
module lcd_host_if
  import lcd_host_pkg::*;
#(
  parameter int DISP_AW  = 7,
  parameter int CGEN_AW  = 6,
  parameter int SEGM_AW  = 5,
  parameter int BUSY_CYC = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busRs,
  input  logic       busRw,
  input  logic       busEn,
  input  logic [7:0] busDin,
  output logic [7:0] busDout
);
  ctl_s       ctl;
  logic       busyQ;
  logic [6:0] acQ;
  tgt_e       tgtQ;
  logic       dirIncQ;

  lcd_host_ctl #(.BUSY_CYC(BUSY_CYC)) u_ctl (
    .clk(clk), .rstN(rstN), .busRs(busRs), .busRw(busRw),
    .busEn(busEn), .busDin(busDin), .ctl(ctl), .busy(busyQ)
  );

  lcd_host_dp #(.DISP_AW(DISP_AW), .CGEN_AW(CGEN_AW), .SEGM_AW(SEGM_AW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busy(busyQ), .busRs(busRs),
    .busDout(busDout), .acQ(acQ), .tgtQ(tgtQ), .dirIncQ(dirIncQ)
  );

endmodule

// File: rtl/lcd_host_if_chk.sv
module lcd_host_if_chk
  import lcd_host_pkg::*;
#(
  parameter int DISP_AW = 7,
  parameter int CGEN_AW = 6,
  parameter int SEGM_AW = 5
) (
  input logic       clk,
  input logic       rstN,
  input ctl_s       ctl,
  input logic       busyQ,
  input logic [6:0] acQ,
  input tgt_e       tgtQ,
  input logic       dirIncQ
);
  localparam logic [6:0] DISP_MASK = 7'((1 << DISP_AW) - 1);
  logic anyOp;
  assign anyOp = ctl.memWr | ctl.acLoad | ctl.acStep | ctl.dirLoad;

  a_r10_idle_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> !anyOp);

  a_r9_busy_follows_op: assert property (@(posedge clk) disable iff (!rstN)
    anyOp |=> busyQ);

  a_r4_fetch_after_load: assert property (@(posedge clk) disable iff (!rstN)
    ctl.acLoad |=> ctl.fetch);

  a_r3_counter_loaded: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.acLoad && ctl.tgtVal == TGT_DISP) |=> acQ == ($past(ctl.acVal) & DISP_MASK));

  a_r7_increment_step: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.acStep && dirIncQ && tgtQ == TGT_DISP) |=> acQ == ((($past(acQ)) + 7'd1) & DISP_MASK));

  a_r8_cgen_range: assert property (@(posedge clk) disable iff (!rstN)
    (tgtQ == TGT_CGEN) |-> (acQ >> CGEN_AW) == 7'd0);

  a_r8_segm_range: assert property (@(posedge clk) disable iff (!rstN)
    (tgtQ == TGT_SEGM) |-> (acQ >> SEGM_AW) == 7'd0);

endmodule

bind lcd_host_if lcd_host_if_chk #(
  .DISP_AW(DISP_AW), .CGEN_AW(CGEN_AW), .SEGM_AW(SEGM_AW)
) u_chk (
  .clk(clk), .rstN(rstN), .ctl(ctl), .busyQ(busyQ),
  .acQ(acQ), .tgtQ(tgtQ), .dirIncQ(dirIncQ)
);

// File: tb/lcd_host_if_bench.sv
module lcd_host_if_bench;
  localparam int BUSY = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busRs = 1'b0, busRw = 1'b0, busEn = 1'b0;
  logic [7:0] busDin = '0;
  logic [7:0] busDout;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [7:0] exp;
  } item_t;
  item_t expQ[$];

  always #4 clk = ~clk;

  lcd_host_if #(.BUSY_CYC(BUSY)) u_lcd_host_if (
    .clk(clk), .rstN(rstN), .busRs(busRs), .busRw(busRw),
    .busEn(busEn), .busDin(busDin), .busDout(busDout)
  );

  // monitor: compares design output against queued expectations
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      checks++;
      if (busDout !== it.exp) begin
        fails++;
        $display("FAIL %s: got 0x%02h expected 0x%02h", it.tag, busDout, it.exp);
      end
    end
  end

  task automatic access(input logic rs, input logic rw, input logic [7:0] d);
    @(posedge clk); #1;
    busRs = rs; busRw = rw; busDin = d; busEn = 1'b1;
    repeat (3) @(posedge clk);
    #1 busEn = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  task automatic readExp(input logic rs, input logic [7:0] exp, input string tag);
    item_t it;
    @(posedge clk); #1;
    busRs = rs; busRw = 1'b1; busEn = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    it.tag = tag; it.exp = exp;
    expQ.push_back(it);
    @(posedge clk); #1 busEn = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  task automatic settle();
    repeat (BUSY + 16) @(posedge clk);
  endtask

  task automatic cmd(input logic [7:0] d);
    access(1'b0, 1'b0, d); settle();
  endtask

  task automatic wrData(input logic [7:0] d);
    access(1'b1, 1'b0, d); settle();
  endtask

  task automatic rdData(input logic [7:0] exp, input string tag);
    readExp(1'b1, exp, tag); settle();
  endtask

  task automatic status(input logic [7:0] exp, input string tag);
    readExp(1'b0, exp, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (2) @(posedge clk);

    status(8'h00, "R1 reset status");

    // R3/R5: display RAM address 5, three writes
    cmd(8'h85);
    status(8'h05, "R3 display address set");
    wrData(8'h11); wrData(8'h22); wrData(8'h33);
    status(8'h08, "R5 counter after writes");

    // R4/R6: prefetch and sequential reads
    cmd(8'h85);
    rdData(8'h11, "R4 prefetch after address set");
    rdData(8'h22, "R6 sequential read 1");
    rdData(8'h33, "R6 sequential read 2");
    status(8'h08, "R6 counter after reads");
    status(8'h08, "R2 status read has no effect");

    // R11: independent RAMs at address 5
    cmd(8'h45); wrData(8'hA5);
    cmd(8'h25); wrData(8'h5A);
    cmd(8'h45);
    status(8'h05, "R3 cgen address set");
    rdData(8'hA5, "R11 cgen word");
    cmd(8'h25);
    rdData(8'h5A, "R3 segm word");
    cmd(8'h85);
    rdData(8'h11, "R11 display word intact");

    // R7: decrement direction
    cmd(8'h04);
    cmd(8'h87);
    wrData(8'h77);
    status(8'h06, "R7 decrement after write");
    wrData(8'h66);
    status(8'h05, "R7 second decrement");
    cmd(8'h87);
    rdData(8'h77, "R7 read at 7");
    rdData(8'h66, "R7 read steps down to 6");

    // R8: wraps
    cmd(8'h80); wrData(8'hEE);
    status(8'h7F, "R8 display wrap down");
    cmd(8'h40); wrData(8'hC1);
    status(8'h3F, "R8 cgen wrap down");
    cmd(8'h06);
    cmd(8'hFF); wrData(8'hDD);
    status(8'h00, "R8 display wrap up");
    cmd(8'h7F); wrData(8'hC3);
    status(8'h00, "R8 cgen wrap up");
    cmd(8'h3F); wrData(8'hB4);
    status(8'h00, "R8 segm wrap up");

    // R9/R10: busy window
    cmd(8'h90); wrData(8'h42);
    access(1'b0, 1'b0, 8'h90);
    status(8'h90, "R9 busy flag set after instruction");
    access(1'b1, 1'b0, 8'h99);
    access(1'b0, 1'b0, 8'h81);
    status(8'h90, "R10 ignored while busy");
    settle();
    status(8'h10, "R9 busy cleared");
    rdData(8'h42, "R10 ignored write left RAM intact");
    status(8'h11, "R10 ignored instruction kept counter");

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule